// File: doc/BRIEF.md
# SCSI Initiator Command Sequencer

This block is the command engine of a SCSI initiator controller. Software writes a command byte; the sequencer decodes it and, one clock later, updates the status, interrupt and sequence-step registers, the FIFO flag count and the transfer counter, and raises the interrupt line when the command calls for it. Bit 7 of the command byte picks DMA mode. The low seven bits pick the operation.

Selection looks up the addressed target in a presence vector. A present target answers through a simple responder interface: a signed data length (positive for data-in, negative for data-out, zero for none) and a status byte. Moving bytes is left to an external transfer unit. The sequencer hands that unit a one-cycle start request with a kind, a length and, for responses, a two-byte payload. When the unit reports completion, the sequencer finishes the pending step. Bus signalling is outside the block.

Top module: `scsi_cmd_seq`

## Requirements
- R1: After rst_n, and one cycle after chip reset (opcode 0x02), every register output reads 0, irq is low and no transfer is pending.
- R2: A recognised command with bit 7 set sets dma_mode and loads xfer_count from the last value written with cnt_we. With bit 7 clear it clears dma_mode and leaves xfer_count unchanged. A count write clears status bit 4 (terminal count, 0x10).
- R3: Flush (0x01) sets the interrupt register to 0x08 and the sequence step to 0, and does not raise irq.
- R4: Bus reset (0x03) sets the interrupt register to 0x80. It raises irq only when cfg1 bit 6 is 0.
- R5: Select with ATN (0x42) or select with ATN and stop (0x43) on a target whose bit in tgt_present is 0 sets the status field to 0, the interrupt register to 0x20 and the sequence step to 0, and raises irq. The target is bus_id[2:0].
- R6: Select with ATN on a present target sets the interrupt register to 0x18 and the sequence step to 4, and raises irq. The status field becomes 0x11 for a positive tgt_len and 0x10 for a negative one. It is left unchanged for zero.
- R7: Select with ATN and stop on a present target sets status 0x12, interrupt 0x18 and step 4, raises irq, and holds the command. A following transfer command (0x10) completes it as in R6: at once without bit 7; with bit 7 set, after xfer_done that follows a start of kind 2 (command) whose length is the smaller of 32 and the count (a count of 0 means 65536).
- R8: A DMA transfer command with no held command clears status bit 4. It issues a start of kind 0 (data-in) or 1 (data-out) whose length is the smaller of the count and the remaining data length. On xfer_done it sets status bit 4, interrupt 0x10, step 0, FIFO flags 0 and count 0, raises irq, and reduces the remaining length by the length moved.
- R9: Command complete (0x11) issues a start of kind 3 with length 2 and payload {0x00, tgt_status} and raises irq. In DMA mode it sets status 0x13, interrupt 0x18 and step 4. Without bit 7 it sets the FIFO flags to 2 and leaves status, interrupt and step unchanged.
- R10: Message accepted (0x12) acts as R9, then sets the interrupt register to 0x20 and the step to 0.
- R11: An unrecognised opcode changes only cmd_reg. dma_mode, xfer_count, status, interrupt, step, flags and irq are kept, and no start is issued.
- R12: status_reg bit 7 always equals irq. A pulse on intr_rd lowers irq and clears status bits 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_wdata | input | 8 | Command byte |
| cnt_we | input | 1 | Transfer count write strobe |
| cnt_wdata | input | CNT_W | Transfer count value |
| bus_id | input | 8 | Bus ID register; bits 2:0 address the target |
| cfg1 | input | 8 | Configuration 1 register; bit 6 suppresses the bus-reset interrupt |
| tgt_present | input | NUM_TGT | One bit per attached target |
| tgt_len | input | LEN_W | Signed data length answered by the selected target |
| tgt_status | input | 8 | Status byte answered by the target |
| intr_rd | input | 1 | Interrupt register read strobe |
| xfer_done | input | 1 | Transfer unit completion pulse |
| cmd_reg | output | 8 | Last command byte written |
| status_reg | output | 8 | Status register, bit 7 = irq |
| intr_reg | output | 8 | Interrupt cause register |
| seq_step | output | 3 | Sequence step |
| fifo_flags | output | 5 | FIFO byte count flags |
| xfer_count | output | CNT_W | Transfer counter |
| dma_mode | output | 1 | Last recognised command used DMA |
| irq | output | 1 | Interrupt request |
| xfer_start | output | 1 | One-cycle start request to the transfer unit |
| xfer_kind | output | 2 | 0 data-in, 1 data-out, 2 command bytes, 3 response bytes |
| xfer_len | output | CNT_W+1 | Byte length of the requested transfer |
| xfer_payload | output | 16 | Response bytes, status byte in the low half |

## Verification
The properties assume that at most one of cmd_we, cnt_we, intr_rd and xfer_done is active in a cycle where a command is being checked. They also assume that xfer_done arrives only after a start. The bench drives each strobe alone, on the falling edge. It pulses xfer_done only after it has seen the matching start. The target inputs stay constant across each command, and responder values are set before the strobe.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

  // Operation codes carried in the low seven bits of the command byte.
  localparam logic [6:0] CODE_NOP     = 7'h00;
  localparam logic [6:0] CODE_FLUSH   = 7'h01;
  localparam logic [6:0] CODE_CHIPRST = 7'h02;
  localparam logic [6:0] CODE_BUSRST  = 7'h03;
  localparam logic [6:0] CODE_XFER    = 7'h10;
  localparam logic [6:0] CODE_CCSEQ   = 7'h11;
  localparam logic [6:0] CODE_MSGOK   = 7'h12;
  localparam logic [6:0] CODE_SEL     = 7'h42;
  localparam logic [6:0] CODE_SELSTOP = 7'h43;

  typedef enum logic [3:0] {
    OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER,
    OP_CCSEQ, OP_MSGOK, OP_SEL, OP_SELSTOP, OP_BAD
  } op_e;

  // Interrupt cause values.
  localparam logic [7:0] INT_FC   = 8'h08;
  localparam logic [7:0] INT_BS   = 8'h10;
  localparam logic [7:0] INT_DISC = 8'h20;
  localparam logic [7:0] INT_BRST = 8'h80;

  // Status field (bits 6:0; bit 7 is the interrupt line).
  localparam logic [6:0] ST_TC   = 7'h10;
  localparam logic [6:0] ST_DOUT = 7'h00;
  localparam logic [6:0] ST_DIN  = 7'h01;
  localparam logic [6:0] ST_CMD  = 7'h02;
  localparam logic [6:0] ST_STAT = 7'h03;

  localparam logic [2:0] STEP_DONE = 3'd4;

  typedef enum logic [1:0] {XK_DIN, XK_DOUT, XK_CMD, XK_RESP} xkind_e;
  typedef enum logic [1:0] {PD_NONE, PD_CMD, PD_DATA} pend_e;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_seq_pkg::*;
(
  input  logic [6:0] code,
  output op_e        op
);
  always_comb begin
    unique case (code)
      CODE_NOP:     op = OP_NOP;
      CODE_FLUSH:   op = OP_FLUSH;
      CODE_CHIPRST: op = OP_CHIPRST;
      CODE_BUSRST:  op = OP_BUSRST;
      CODE_XFER:    op = OP_XFER;
      CODE_CCSEQ:   op = OP_CCSEQ;
      CODE_MSGOK:   op = OP_MSGOK;
      CODE_SEL:     op = OP_SEL;
      CODE_SELSTOP: op = OP_SELSTOP;
      default:      op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/scsi_sel_resolve.sv
module scsi_sel_resolve
  import scsi_seq_pkg::*;
#(
  parameter int NUM_TGT = 8,   // at most 8: the ID field is three bits
  parameter int LEN_W   = 24
) (
  input  logic [2:0]              tgt_id,
  input  logic [NUM_TGT-1:0]      present_vec,
  input  logic signed [LEN_W-1:0] dlen,
  output logic                    present,
  output logic                    has_data,
  output logic [6:0]              phase_stat
);
  always_comb begin
    present = 1'b0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (int'(tgt_id) == i) present = present_vec[i];
    end
    has_data   = (dlen != '0);
    phase_stat = ST_TC | ((dlen > 0) ? ST_DIN : ST_DOUT);
  end
endmodule

// File: rtl/scsi_xfer_len.sv
module scsi_xfer_len #(
  parameter int CNT_W   = 16,
  parameter int LEN_W   = 24,
  parameter int CMD_MAX = 32
) (
  input  logic [CNT_W-1:0]        count,
  input  logic signed [LEN_W-1:0] remain,
  input  logic                    cmd_mode,
  output logic [CNT_W:0]          len
);
  localparam int W = (LEN_W > CNT_W + 1) ? LEN_W : CNT_W + 1;

  logic [W-1:0] avail, limit, mag;

  always_comb begin
    // A zero count stands for the full counter range.
    avail = (count == '0) ? (W'(1) << CNT_W) : W'(count);
    mag   = (remain < 0) ? W'(-remain) : W'(remain);
    limit = cmd_mode ? W'(CMD_MAX) : mag;
    len   = (avail < limit) ? (CNT_W+1)'(avail) : (CNT_W+1)'(limit);
  end
endmodule

// File: rtl/scsi_cmd_seq.sv
module scsi_cmd_seq
  import scsi_seq_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int CNT_W   = 16,
  parameter int LEN_W   = 24,   // must exceed CNT_W + 1
  parameter int CMD_MAX = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_we,
  input  logic [7:0]              cmd_wdata,
  input  logic                    cnt_we,
  input  logic [CNT_W-1:0]        cnt_wdata,
  input  logic [7:0]              bus_id,
  input  logic [7:0]              cfg1,
  input  logic [NUM_TGT-1:0]      tgt_present,
  input  logic signed [LEN_W-1:0] tgt_len,
  input  logic [7:0]              tgt_status,
  input  logic                    intr_rd,
  input  logic                    xfer_done,
  output logic [7:0]              cmd_reg,
  output logic [7:0]              status_reg,
  output logic [7:0]              intr_reg,
  output logic [2:0]              seq_step,
  output logic [4:0]              fifo_flags,
  output logic [CNT_W-1:0]        xfer_count,
  output logic                    dma_mode,
  output logic                    irq,
  output logic                    xfer_start,
  output logic [1:0]              xfer_kind,
  output logic [CNT_W:0]          xfer_len,
  output logic [15:0]             xfer_payload
);
  localparam int PAD_W = LEN_W - CNT_W - 1;

  logic unused_in;
  assign unused_in = ^{bus_id[7:3], cfg1[7], cfg1[5:0]};

  // State registers and their next values.
  logic [7:0]              cmd_q, cmd_n;
  logic [6:0]              stat_q, stat_n;
  logic [7:0]              intr_q, intr_n;
  logic [2:0]              seq_q, seq_n;
  logic [4:0]              flags_q, flags_n;
  logic [CNT_W-1:0]        cnt_q, cnt_n;
  logic [CNT_W-1:0]        cntw_q, cntw_n;
  logic                    dma_q, dma_n;
  logic                    irq_q, irq_n;
  logic                    hold_q, hold_n;
  pend_e                   pend_q, pend_n;
  logic signed [LEN_W-1:0] size_q, size_n;
  logic                    start_q, start_n;
  xkind_e                  kind_q, kind_n;
  logic [CNT_W:0]          len_q, len_n;
  logic [15:0]             pay_q, pay_n;

  op_e            op;
  logic           sel_present, sel_has_data;
  logic [6:0]     sel_stat;
  logic [CNT_W:0] calc_len;
  logic           go_sel;
  logic signed [LEN_W-1:0] len_ext;

  scsi_cmd_decode u_dec (
    .code (cmd_wdata[6:0]),
    .op   (op)
  );

  scsi_sel_resolve #(.NUM_TGT(NUM_TGT), .LEN_W(LEN_W)) u_sel (
    .tgt_id      (bus_id[2:0]),
    .present_vec (tgt_present),
    .dlen        (tgt_len),
    .present     (sel_present),
    .has_data    (sel_has_data),
    .phase_stat  (sel_stat)
  );

  scsi_xfer_len #(.CNT_W(CNT_W), .LEN_W(LEN_W), .CMD_MAX(CMD_MAX)) u_len (
    .count    (cntw_q),
    .remain   (size_q),
    .cmd_mode (hold_q),
    .len      (calc_len)
  );

  assign len_ext = $signed({{PAD_W{1'b0}}, len_q});

  // Next-state logic.
  always_comb begin
    cmd_n   = cmd_q;   stat_n  = stat_q;  intr_n = intr_q; seq_n  = seq_q;
    flags_n = flags_q; cnt_n   = cnt_q;   cntw_n = cntw_q; dma_n  = dma_q;
    irq_n   = irq_q;   hold_n  = hold_q;  pend_n = pend_q; size_n = size_q;
    start_n = 1'b0;    kind_n  = kind_q;  len_n  = len_q;  pay_n  = pay_q;
    go_sel  = 1'b0;

    if (cnt_we) begin
      cntw_n = cnt_wdata;
      stat_n = stat_n & ~ST_TC;
    end

    if (intr_rd) begin
      irq_n       = 1'b0;
      stat_n[6:5] = 2'b00;
    end

    // Completion from the transfer unit.
    if (xfer_done) begin
      unique case (pend_q)
        PD_CMD: begin
          pend_n = PD_NONE;
          hold_n = 1'b0;
          go_sel = 1'b1;
        end
        PD_DATA: begin
          pend_n  = PD_NONE;
          stat_n  = stat_n | ST_TC;
          intr_n  = INT_BS;
          seq_n   = 3'd0;
          flags_n = 5'd0;
          cnt_n   = '0;
          irq_n   = 1'b1;
          size_n  = (size_q < 0) ? size_q + len_ext : size_q - len_ext;
        end
        default: ;
      endcase
    end

    if (cmd_we) begin
      cmd_n = cmd_wdata;
      if (op != OP_BAD) begin
        dma_n = cmd_wdata[7];
        if (cmd_wdata[7]) cnt_n = cntw_q;
      end
      unique case (op)
        OP_FLUSH: begin
          intr_n = INT_FC;
          seq_n  = 3'd0;
        end
        OP_CHIPRST: begin
          cmd_n = '0; stat_n = '0; intr_n = '0; seq_n = '0; flags_n = '0;
          cnt_n = '0; cntw_n = '0; dma_n = 1'b0; irq_n = 1'b0;
          hold_n = 1'b0; pend_n = PD_NONE; size_n = '0; go_sel = 1'b0;
        end
        OP_BUSRST: begin
          intr_n = INT_BRST;
          if (!cfg1[6]) irq_n = 1'b1;
        end
        OP_SEL, OP_SELSTOP: begin
          size_n = '0;
          pend_n = PD_NONE;
          hold_n = 1'b0;
          go_sel = 1'b0;
          if (!sel_present) begin
            stat_n = '0;
            intr_n = INT_DISC;
            seq_n  = 3'd0;
            irq_n  = 1'b1;
          end else if (op == OP_SELSTOP) begin
            hold_n = 1'b1;
            stat_n = ST_TC | ST_CMD;
            intr_n = INT_BS | INT_FC;
            seq_n  = STEP_DONE;
            irq_n  = 1'b1;
          end else begin
            go_sel = 1'b1;
          end
        end
        OP_XFER: begin
          if (cmd_wdata[7]) begin
            stat_n  = stat_n & ~ST_TC;
            start_n = 1'b1;
            len_n   = calc_len;
            if (hold_q) begin
              kind_n = XK_CMD;
              pend_n = PD_CMD;
            end else begin
              kind_n = (size_q < 0) ? XK_DOUT : XK_DIN;
              pend_n = PD_DATA;
            end
          end else if (hold_q) begin
            hold_n = 1'b0;
            go_sel = 1'b1;
          end
        end
        OP_CCSEQ, OP_MSGOK: begin
          start_n = 1'b1;
          kind_n  = XK_RESP;
          len_n   = (CNT_W+1)'(2);
          pay_n   = {8'h00, tgt_status};
          irq_n   = 1'b1;
          if (cmd_wdata[7]) begin
            stat_n = ST_TC | ST_STAT;
            intr_n = INT_BS | INT_FC;
            seq_n  = STEP_DONE;
          end else begin
            flags_n = 5'd2;
          end
          if (op == OP_MSGOK) begin
            intr_n = INT_DISC;
            seq_n  = 3'd0;
          end
        end
        default: ;
      endcase
    end

    // Command phase finished: hand the command to the target.
    if (go_sel) begin
      if (sel_has_data) stat_n = sel_stat;
      intr_n = INT_BS | INT_FC;
      seq_n  = STEP_DONE;
      irq_n  = 1'b1;
      size_n = tgt_len;
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; stat_q <= '0; intr_q <= '0; seq_q <= '0; flags_q <= '0;
      cnt_q <= '0; cntw_q <= '0; dma_q <= 1'b0; irq_q <= 1'b0;
      hold_q <= 1'b0; pend_q <= PD_NONE; size_q <= '0;
      start_q <= 1'b0; kind_q <= XK_DIN; len_q <= '0; pay_q <= '0;
    end else begin
      cmd_q <= cmd_n; stat_q <= stat_n; intr_q <= intr_n; seq_q <= seq_n;
      flags_q <= flags_n; cnt_q <= cnt_n; cntw_q <= cntw_n; dma_q <= dma_n;
      irq_q <= irq_n; hold_q <= hold_n; pend_q <= pend_n; size_q <= size_n;
      start_q <= start_n;
      if (start_n) begin
        kind_q <= kind_n;
        len_q  <= len_n;
        pay_q  <= pay_n;
      end
    end
  end

  assign cmd_reg      = cmd_q;
  assign status_reg   = {irq_q, stat_q};
  assign intr_reg     = intr_q;
  assign seq_step     = seq_q;
  assign fifo_flags   = flags_q;
  assign xfer_count   = cnt_q;
  assign dma_mode     = dma_q;
  assign irq          = irq_q;
  assign xfer_start   = start_q;
  assign xfer_kind    = kind_q;
  assign xfer_len     = len_q;
  assign xfer_payload = pay_q;

endmodule

// File: rtl/scsi_cmd_seq_chk.sv
module scsi_cmd_seq_chk
  import scsi_seq_pkg::*;
#(
  parameter int NUM_TGT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_we,
  input logic [7:0]         cmd_wdata,
  input logic               cnt_we,
  input logic [7:0]         bus_id,
  input logic [7:0]         cfg1,
  input logic [NUM_TGT-1:0] tgt_present,
  input logic               intr_rd,
  input logic               xfer_done,
  input logic [7:0]         status_reg,
  input logic [7:0]         intr_reg,
  input logic [2:0]         seq_step,
  input logic               irq,
  input logic               xfer_start
);
  logic [6:0] code;
  logic       quiet, absent, known;

  assign code  = cmd_wdata[6:0];
  assign quiet = !cnt_we && !intr_rd && !xfer_done;

  always_comb begin
    absent = 1'b1;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (int'(bus_id[2:0]) == i) absent = !tgt_present[i];
    end
    known = (code == CODE_NOP) || (code == CODE_FLUSH) || (code == CODE_CHIPRST) ||
            (code == CODE_BUSRST) || (code == CODE_XFER) || (code == CODE_CCSEQ) ||
            (code == CODE_MSGOK) || (code == CODE_SEL) || (code == CODE_SELSTOP);
  end

  // R1: chip reset empties the visible registers
  p_chip_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && code == CODE_CHIPRST) |=> (!irq && intr_reg == 8'h00 && status_reg == 8'h00));

  // R3: flush does not raise the interrupt
  p_flush_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && code == CODE_FLUSH && !irq && quiet) |=> (!irq && intr_reg == INT_FC && seq_step == 3'd0));

  // R4: bus reset interrupt suppressed by cfg1 bit 6
  p_busrst_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && code == CODE_BUSRST && cfg1[6] && !irq && quiet) |=> (!irq && intr_reg == INT_BRST));

  p_busrst_raised_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && code == CODE_BUSRST && !cfg1[6]) |=> irq);

  // R5: selecting an absent target reports a disconnect
  p_absent_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (code == CODE_SEL || code == CODE_SELSTOP) && absent)
      |=> (irq && intr_reg == INT_DISC && seq_step == 3'd0 && status_reg == 8'h80));

  // R11: an unknown opcode leaves the visible state alone
  p_unknown_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !known && quiet)
      |=> ($stable(intr_reg) && $stable(seq_step) && $stable(status_reg) && !xfer_start));

  // R12: an interrupt read lowers the line when nothing else is active
  p_intr_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_rd && !cmd_we && !xfer_done) |=> (!irq && !status_reg[7]));

endmodule

bind scsi_cmd_seq scsi_cmd_seq_chk #(.NUM_TGT(NUM_TGT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_we      (cmd_we),
  .cmd_wdata   (cmd_wdata),
  .cnt_we      (cnt_we),
  .bus_id      (bus_id),
  .cfg1        (cfg1),
  .tgt_present (tgt_present),
  .intr_rd     (intr_rd),
  .xfer_done   (xfer_done),
  .status_reg  (status_reg),
  .intr_reg    (intr_reg),
  .seq_step    (seq_step),
  .irq         (irq),
  .xfer_start  (xfer_start)
);

// File: tb/scsi_cmd_seq_test.sv
module scsi_cmd_seq_test;
  localparam int NUM_TGT = 8;
  localparam int CNT_W   = 16;
  localparam int LEN_W   = 24;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    cmd_we = 1'b0;
  logic [7:0]              cmd_wdata = '0;
  logic                    cnt_we = 1'b0;
  logic [CNT_W-1:0]        cnt_wdata = '0;
  logic [7:0]              bus_id = '0;
  logic [7:0]              cfg1 = '0;
  logic [NUM_TGT-1:0]      tgt_present = 8'b0000_0100;
  logic signed [LEN_W-1:0] tgt_len = '0;
  logic [7:0]              tgt_status = '0;
  logic                    intr_rd = 1'b0;
  logic                    xfer_done = 1'b0;

  logic [7:0]       cmd_reg, status_reg, intr_reg;
  logic [2:0]       seq_step;
  logic [4:0]       fifo_flags;
  logic [CNT_W-1:0] xfer_count;
  logic             dma_mode, irq, xfer_start;
  logic [1:0]       xfer_kind;
  logic [CNT_W:0]   xfer_len;
  logic [15:0]      xfer_payload;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  scsi_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .bus_id(bus_id), .cfg1(cfg1),
    .tgt_present(tgt_present), .tgt_len(tgt_len), .tgt_status(tgt_status),
    .intr_rd(intr_rd), .xfer_done(xfer_done), .cmd_reg(cmd_reg),
    .status_reg(status_reg), .intr_reg(intr_reg), .seq_step(seq_step),
    .fifo_flags(fifo_flags), .xfer_count(xfer_count), .dma_mode(dma_mode),
    .irq(irq), .xfer_start(xfer_start), .xfer_kind(xfer_kind),
    .xfer_len(xfer_len), .xfer_payload(xfer_payload)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Each strobe is driven for one cycle from a falling edge; the task
  // returns on the next falling edge, when the registered result is visible.
  task automatic wr_cmd(logic [7:0] v);
    @(negedge clk); cmd_wdata = v; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_cnt(logic [CNT_W-1:0] v);
    @(negedge clk); cnt_wdata = v; cnt_we = 1'b1;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic rd_int();
    @(negedge clk); intr_rd = 1'b1;
    @(negedge clk); intr_rd = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "status", status_reg, 8'h00);
    chk("R1", "intr", intr_reg, 8'h00);
    chk("R1", "step", seq_step, 3'd0);
    chk("R1", "flags", fifo_flags, 5'd0);
    chk("R1", "cmd", cmd_reg, 8'h00);
    chk("R1", "count", xfer_count, 16'h0);
    chk("R1", "irq", irq, 1'b0);
  endtask

  task automatic t_flush();
    wr_cmd(8'h01);
    chk("R3", "intr", intr_reg, 8'h08);
    chk("R3", "step", seq_step, 3'd0);
    chk("R3", "irq", irq, 1'b0);
    chk("R3", "cmd", cmd_reg, 8'h01);
  endtask

  task automatic t_busreset();
    cfg1 = 8'h40;
    wr_cmd(8'h03);
    chk("R4", "intr masked", intr_reg, 8'h80);
    chk("R4", "irq masked", irq, 1'b0);
    cfg1 = 8'h00;
    wr_cmd(8'h03);
    chk("R4", "irq raised", irq, 1'b1);
    chk("R12", "status bit7 set", status_reg, 8'h80);
    rd_int();
    chk("R12", "irq after read", irq, 1'b0);
    chk("R12", "status after read", status_reg, 8'h00);
  endtask

  task automatic t_absent();
    bus_id = 8'h05;
    wr_cmd(8'h42);
    chk("R5", "status", status_reg, 8'h80);
    chk("R5", "intr", intr_reg, 8'h20);
    chk("R5", "step", seq_step, 3'd0);
    rd_int();
    wr_cmd(8'h43);
    chk("R5", "stop status", status_reg, 8'h80);
    chk("R5", "stop intr", intr_reg, 8'h20);
    rd_int();
    bus_id = 8'h02;
  endtask

  task automatic t_select();
    tgt_len = 100;
    wr_cmd(8'h42);
    chk("R6", "status data-in", status_reg, 8'h91);
    chk("R6", "intr", intr_reg, 8'h18);
    chk("R6", "step", seq_step, 3'd4);
    rd_int();
    wr_cnt(16'h0123);
    chk("R2", "count write clears TC", status_reg, 8'h01);
    tgt_len = -50;
    wr_cmd(8'h42);
    chk("R6", "status data-out", status_reg, 8'h90);
    rd_int();
    wr_cmd(8'h02);
    chk("R1", "chip reset status", status_reg, 8'h00);
    chk("R1", "chip reset cmd", cmd_reg, 8'h00);
    tgt_len = 0;
    wr_cmd(8'h42);
    chk("R6", "status no data", status_reg, 8'h80);
    chk("R6", "intr no data", intr_reg, 8'h18);
    rd_int();
  endtask

  task automatic t_dma_bit();
    wr_cnt(16'h0123);
    wr_cmd(8'h80);
    chk("R2", "dma set", dma_mode, 1'b1);
    chk("R2", "count reload", xfer_count, 16'h0123);
    wr_cnt(16'h0456);
    wr_cmd(8'h00);
    chk("R2", "dma clear", dma_mode, 1'b0);
    chk("R2", "count kept", xfer_count, 16'h0123);
    wr_cmd(8'h81);
    chk("R2", "count reload flush", xfer_count, 16'h0456);
  endtask

  task automatic t_selstop();
    wr_cmd(8'h02);
    tgt_len = 40;
    wr_cmd(8'h43);
    chk("R7", "status", status_reg, 8'h92);
    chk("R7", "intr", intr_reg, 8'h18);
    chk("R7", "step", seq_step, 3'd4);
    rd_int();
    wr_cnt(16'h0000);
    wr_cmd(8'h90);
    chk("R7", "start", xfer_start, 1'b1);
    chk("R7", "kind", xfer_kind, 2'd2);
    chk("R7", "len", xfer_len, 17'd32);
    chk("R7", "status TC cleared", status_reg, 8'h02);
    @(negedge clk);
    chk("R7", "start one cycle", xfer_start, 1'b0);
    done_pulse();
    chk("R7", "done status", status_reg, 8'h91);
    chk("R7", "done intr", intr_reg, 8'h18);
    rd_int();
    wr_cmd(8'h43);
    chk("R7", "pio hold status", status_reg, 8'h92);
    rd_int();
    wr_cmd(8'h10);
    chk("R7", "pio status", status_reg, 8'h91);
    chk("R7", "pio no start", xfer_start, 1'b0);
    rd_int();
  endtask

  task automatic t_data();
    tgt_len = 100;
    wr_cmd(8'h42);
    rd_int();
    wr_cnt(16'd64);
    wr_cmd(8'h90);
    chk("R8", "start", xfer_start, 1'b1);
    chk("R8", "kind in", xfer_kind, 2'd0);
    chk("R8", "len count", xfer_len, 17'd64);
    chk("R8", "status", status_reg, 8'h01);
    done_pulse();
    chk("R8", "done status", status_reg, 8'h91);
    chk("R8", "done intr", intr_reg, 8'h10);
    chk("R8", "done step", seq_step, 3'd0);
    chk("R8", "done count", xfer_count, 16'd0);
    rd_int();
    wr_cnt(16'd64);
    wr_cmd(8'h90);
    chk("R8", "len remaining", xfer_len, 17'd36);
    done_pulse();
    rd_int();
    tgt_len = -50;
    wr_cmd(8'h42);
    rd_int();
    wr_cnt(16'd16);
    wr_cmd(8'h90);
    chk("R8", "kind out", xfer_kind, 2'd1);
    chk("R8", "len out", xfer_len, 17'd16);
    done_pulse();
    rd_int();
  endtask

  task automatic t_resp();
    tgt_status = 8'h02;
    wr_cmd(8'h91);
    chk("R9", "start", xfer_start, 1'b1);
    chk("R9", "kind", xfer_kind, 2'd3);
    chk("R9", "len", xfer_len, 17'd2);
    chk("R9", "payload", xfer_payload, 16'h0002);
    chk("R9", "status", status_reg, 8'h93);
    chk("R9", "intr", intr_reg, 8'h18);
    chk("R9", "step", seq_step, 3'd4);
    rd_int();
    wr_cmd(8'h92);
    chk("R10", "status", status_reg, 8'h93);
    chk("R10", "intr", intr_reg, 8'h20);
    chk("R10", "step", seq_step, 3'd0);
    rd_int();
    wr_cmd(8'h02);
    wr_cmd(8'h11);
    chk("R9", "pio flags", fifo_flags, 5'd2);
    chk("R9", "pio status", status_reg, 8'h80);
    chk("R9", "pio intr", intr_reg, 8'h00);
    rd_int();
    wr_cmd(8'h02);
    wr_cmd(8'h12);
    chk("R10", "pio flags", fifo_flags, 5'd2);
    chk("R10", "pio intr", intr_reg, 8'h20);
    rd_int();
  endtask

  task automatic t_unknown();
    wr_cmd(8'h02);
    wr_cmd(8'h01);
    wr_cmd(8'h9A);
    chk("R11", "cmd", cmd_reg, 8'h9A);
    chk("R11", "intr", intr_reg, 8'h08);
    chk("R11", "step", seq_step, 3'd0);
    chk("R11", "dma", dma_mode, 1'b0);
    chk("R11", "status", status_reg, 8'h00);
    chk("R11", "start", xfer_start, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flush();
    t_busreset();
    t_absent();
    t_select();
    t_dma_bit();
    t_selstop();
    t_data();
    t_resp();
    t_unknown();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule